// File: doc/BRIEF.md
# Dual-Channel IDE PIO Timing Register Bank

This block sits on the host side of a local-bus IDE accelerator. It holds the per-drive PIO timing words and the port control setting in a four-byte register window. Pins sampled from board straps choose the window base: either 0x30 or 0xB0. Byte writes from the host update the two timing registers and the control register. Byte reads return those registers or a read-only configuration byte, which reports the strap settings and a device identity nibble.

For every drive access, the block takes the channel and the master/slave select. It then presents, one cycle later, the 8-bit timing word that applies to that access. Control bit 0 chooses the routing. In single-port routing, the primary port's master and slave are spread over the two timers. In dual-port routing, each port owns one timer. The control register also drives the secondary-port enable and the primary-port read-ahead/post-write buffer enable. Strobe generation, bus clock measurement and drive identification are handled elsewhere.

Top module: `ide_pio_timer_bank`

## Requirements
- R1: Synchronous active-high reset sets the control register to 0x1F, both timing registers to 0x00 (the slowest encoding) and the read data bus to 0xFF. It also leaves the secondary-port enable and the primary buffer enable low.
- R2: A byte address is decoded only when its upper six bits match the window base. The base is 0x30 when strap_hi_base is 0 and 0xB0 when it is 1. Writes outside the window change no register.
- R3: Offset 0 (timer A) and offset 2 (timer B) are read/write and read back exactly the last byte written.
- R4: The configuration byte at offset 1 is built as follows. Bit 0 is strap_pri_base (1 means the primary IDE base at 0x1F0). Bit 1 is strap_hi_base. Bit 2 is strap_slow_bus (1 means a bus at most 33 MHz). Bit 3 is always 1. Bits 7:4 are 1010 when strap_id_alt is 0 and 0101 when it is 1.
- R5: Writes to offset 1 have no effect on any register or output.
- R6: When control bit 0 is 1, the master (drv_unit=0) uses timer A and the slave (drv_unit=1) uses timer B, whatever drv_chan is.
- R7: When control bit 0 is 0, the primary channel (drv_chan=0) uses timer A and the secondary channel (drv_chan=1) uses timer B, whatever drv_unit is.
- R8: The control register at offset 3 is read/write. sec_chan_en is the inverse of control bit 0 and pri_buf_en equals control bit 7. Writing 0x5F leaves both low.
- R9: Read data appears on bus_rdata at the clock edge that samples bus_rd and holds until the next read. timing_word follows the drive select and register contents with one register stage, so a timer write shows up on timing_word one edge after the write edge.
- R10: A read whose address falls outside the window returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_hi_base | input | 1 | Window base strap: 1 = 0xB0, 0 = 0x30 |
| strap_pri_base | input | 1 | IDE base strap: 1 = 0x1F0, 0 = 0x170 |
| strap_slow_bus | input | 1 | Bus speed strap: 1 = at most 33 MHz |
| strap_id_alt | input | 1 | Selects the alternate device identity nibble |
| bus_addr | input | 8 | Host byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Registered read data |
| drv_chan | input | 1 | Channel of the current drive access: 0 primary, 1 secondary |
| drv_unit | input | 1 | Drive on the channel: 0 master, 1 slave |
| timing_word | output | 8 | Registered timing word for the selected drive |
| sec_chan_en | output | 1 | Secondary port enabled |
| pri_buf_en | output | 1 | Primary port read-ahead and post-write buffers enabled |

## Verification
Read data and timing_word each pass through one register. A read is therefore due at the falling edge after the rising edge that sampled bus_rd, and a timing word is due at the falling edge after the edge that sampled the drive select. The driver raises a request strobe with each stimulus and pushes the expected byte into a queue. A monitor registers the strobe on the rising edge and compares only at the following falling edge, so each check lands in the cycle the result is due. The two enable outputs are combinational from the control register and are compared at the falling edge after the write. The one-edge lag of a timer write is checked directly at two successive falling edges.

// File: rtl/ide_pio_timer_bank.sv
module ide_pio_timer_bank #(
  parameter logic [7:0] LO_BASE    = 8'h30,
  parameter logic [7:0] HI_BASE    = 8'hB0,
  parameter logic [7:0] TIMER_INIT = 8'h00,
  parameter logic [7:0] CTRL_INIT  = 8'h1F,
  parameter logic [3:0] ID_MAIN    = 4'hA,
  parameter logic [3:0] ID_ALT     = 4'h5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_hi_base,
  input  logic       strap_pri_base,
  input  logic       strap_slow_bus,
  input  logic       strap_id_alt,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic       drv_chan,
  input  logic       drv_unit,
  output logic [7:0] timing_word,
  output logic       sec_chan_en,
  output logic       pri_buf_en
);
  localparam logic [1:0] OFS_TA   = 2'd0;
  localparam logic [1:0] OFS_CFG  = 2'd1;
  localparam logic [1:0] OFS_TB   = 2'd2;
  localparam logic [1:0] OFS_CTRL = 2'd3;

  logic [7:0] tmr_a, tmr_b, ctrl;
  logic [7:0] cfg_byte, rd_mux;
  logic       hit, use_b;

  assign hit = bus_addr[7:2] == (strap_hi_base ? HI_BASE[7:2] : LO_BASE[7:2]);
  assign cfg_byte = {strap_id_alt ? ID_ALT : ID_MAIN, 1'b1,
                     strap_slow_bus, strap_hi_base, strap_pri_base};
  assign use_b = ctrl[0] ? drv_unit : drv_chan;
  assign sec_chan_en = ~ctrl[0];
  assign pri_buf_en = ctrl[7];

  always_comb begin
    case (bus_addr[1:0])
      OFS_TA:  rd_mux = tmr_a;
      OFS_CFG: rd_mux = cfg_byte;
      OFS_TB:  rd_mux = tmr_b;
      default: rd_mux = ctrl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_a       <= TIMER_INIT;
      tmr_b       <= TIMER_INIT;
      ctrl        <= CTRL_INIT;
      bus_rdata   <= 8'hFF;
      timing_word <= TIMER_INIT;
    end else begin
      if (bus_wr && hit) begin
        case (bus_addr[1:0])
          OFS_TA:   tmr_a <= bus_wdata;
          OFS_TB:   tmr_b <= bus_wdata;
          OFS_CTRL: ctrl  <= bus_wdata;
          default:  ;
        endcase
      end
      if (bus_rd) bus_rdata <= hit ? rd_mux : 8'hFF;
      timing_word <= use_b ? tmr_b : tmr_a;
    end
  end

  // R3
  ta_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit && bus_addr[1:0] == OFS_TA) |=> tmr_a == $past(bus_wdata));

  // R5
  cfg_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit && bus_addr[1:0] == OFS_CFG) |=>
      ($stable(tmr_a) && $stable(tmr_b) && $stable(ctrl)));

  // R2
  miss_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit) |=> ($stable(tmr_a) && $stable(tmr_b) && $stable(ctrl)));

  // R10
  miss_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |=> bus_rdata == 8'hFF);

  // R6
  single_map_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && !drv_unit) |=> timing_word == $past(tmr_a));

  // R7
  dual_map_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[0] && drv_chan) |=> timing_word == $past(tmr_b));

  // R8
  ctrl_atapi_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit && bus_addr[1:0] == OFS_CTRL && bus_wdata == 8'h5F) |=>
      (!pri_buf_en && !sec_chan_en));
endmodule

// File: tb/ide_pio_timer_bank_tb.sv
`timescale 1ns/1ps
module ide_pio_timer_bank_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_hi_base = 1'b0, strap_pri_base = 1'b1, strap_slow_bus = 1'b1, strap_id_alt = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic drv_chan = 1'b0, drv_unit = 1'b0;
  logic [7:0] bus_rdata, timing_word;
  logic sec_chan_en, pri_buf_en;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t rdq[$];
  exp_t twq[$];
  exp_t e_r, e_t;
  logic tw_req = 1'b0;
  logic rd_s = 1'b0, tw_s = 1'b0;

  always #4 clk = ~clk;

  ide_pio_timer_bank u_dut (
    .clk(clk), .rst(rst),
    .strap_hi_base(strap_hi_base), .strap_pri_base(strap_pri_base),
    .strap_slow_bus(strap_slow_bus), .strap_id_alt(strap_id_alt),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .drv_chan(drv_chan), .drv_unit(drv_unit), .timing_word(timing_word),
    .sec_chan_en(sec_chan_en), .pri_buf_en(pri_buf_en)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rd_s <= bus_rd;
    tw_s <= tw_req;
  end

  always @(negedge clk) begin
    if (rd_s) begin
      if (rdq.size() == 0) begin
        errors++; $display("FAIL R9: read result with no expectation, actual %02h expected none", bus_rdata);
      end else begin
        e_r = rdq.pop_front();
        check(bus_rdata, e_r.exp, e_r.tag);
      end
    end
    if (tw_s) begin
      if (twq.size() == 0) begin
        errors++; $display("FAIL R9: timing result with no expectation, actual %02h expected none", timing_word);
      end else begin
        e_t = twq.pop_front();
        check(timing_word, e_t.exp, e_t.tag);
      end
    end
  end

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    rdq.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_drive(input logic ch, input logic un, input logic [7:0] exp, input string tag);
    exp_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    twq.push_back(it);
    drv_chan = ch; drv_unit = un; tw_req = 1'b1;
    @(negedge clk);
    tw_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(bus_rdata, 8'hFF, "R1 rdata");
    check({7'd0, sec_chan_en}, 8'h00, "R1 sec_chan_en");
    check({7'd0, pri_buf_en}, 8'h00, "R1 pri_buf_en");
    do_read(8'h33, 8'h1F, "R1 ctrl");
    do_read(8'h30, 8'h00, "R1 timer A");
    do_read(8'h32, 8'h00, "R1 timer B");
    // R4 config byte, low window
    do_read(8'h31, 8'hAD, "R4 config lo");
    // R3 read back
    do_write(8'h30, 8'hA5);
    do_write(8'h32, 8'h3C);
    do_read(8'h30, 8'hA5, "R3 timer A");
    do_read(8'h32, 8'h3C, "R3 timer B");
    // R5 config write ignored
    do_write(8'h31, 8'h00);
    do_read(8'h31, 8'hAD, "R5 config");
    do_read(8'h30, 8'hA5, "R5 timer A");
    do_read(8'h33, 8'h1F, "R5 ctrl");
    // R2 other window ignored, R10 undecoded reads
    do_write(8'hB0, 8'h77);
    do_write(8'hB3, 8'h00);
    do_read(8'h30, 8'hA5, "R2 timer A");
    do_read(8'h33, 8'h1F, "R2 ctrl");
    do_read(8'hB0, 8'hFF, "R10 other window");
    do_read(8'h40, 8'hFF, "R10 far address");
    // R6 single-port routing
    do_drive(1'b0, 1'b0, 8'hA5, "R6 pri master");
    do_drive(1'b0, 1'b1, 8'h3C, "R6 pri slave");
    do_drive(1'b1, 1'b0, 8'hA5, "R6 chan ignored");
    // R8 and R7 dual-port routing
    do_write(8'h33, 8'h9E);
    check({7'd0, sec_chan_en}, 8'h01, "R8 sec_chan_en");
    check({7'd0, pri_buf_en}, 8'h01, "R8 pri_buf_en");
    do_read(8'h33, 8'h9E, "R8 ctrl read");
    do_drive(1'b0, 1'b1, 8'hA5, "R7 pri slave");
    do_drive(1'b1, 1'b0, 8'h3C, "R7 sec master");
    do_drive(1'b1, 1'b1, 8'h3C, "R7 sec slave");
    // R9 timer write latency on timing_word
    @(negedge clk);
    drv_chan = 1'b1; drv_unit = 1'b0;
    bus_addr = 8'h32; bus_wdata = 8'h5E; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(timing_word, 8'h3C, "R9 before lag");
    @(negedge clk);
    check(timing_word, 8'h5E, "R9 after lag");
    // R8 buffer disable value
    do_write(8'h33, 8'h5F);
    check({7'd0, pri_buf_en}, 8'h00, "R8 5F buf");
    check({7'd0, sec_chan_en}, 8'h00, "R8 5F sec");
    // R2 and R4 high window
    @(negedge clk);
    strap_hi_base = 1'b1; strap_pri_base = 1'b0; strap_slow_bus = 1'b0; strap_id_alt = 1'b1;
    do_read(8'hB1, 8'h5A, "R4 config hi");
    do_read(8'hB0, 8'hA5, "R2 hi timer A");
    do_write(8'hB2, 8'h11);
    do_read(8'hB2, 8'h11, "R2 hi timer B");
    do_read(8'h32, 8'hFF, "R10 old window");
    do_write(8'h30, 8'hEE);
    do_read(8'hB0, 8'hA5, "R2 lo write ignored");
    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule